// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Sequencer

This block is the control sequencer of one DMA channel working in scatter-gather mode. It follows a ring of buffer descriptors held in a word-addressed memory. For each descriptor it reads the link word, control word, source, destination, length and status. It hands the transfer to an external data mover, waits until the mover reports completion, and then writes the status word back with its busy flag cleared. A software control bank enables and halts the chain. It also holds the address of the most recently completed descriptor, shows whether the chain is active, and records a disable-acknowledge event that software clears by writing one to it.

A descriptor occupies consecutive words starting at its base address. The link pointer is at +0, control at +1, source at +2, destination at +3, length at +4 and status at +5. Further per-descriptor words may follow, and the sequencer never touches them. Both the memory port and the mover command port are valid/ready. On the memory port the request fields stay constant while `mem_req_valid` is high and `mem_req_ready` is low. Only one access may be outstanding. Every accepted request, read or write, is answered by exactly one `mem_rsp_valid` pulse, and the sequencer always accepts that response. On the mover port the command stays constant until it is accepted. `mv_done` is a one-cycle pulse that is honoured only while a transfer is in flight.

Software register bank, selected by `cfg_addr`, with writes taking effect at the clock edge while `cfg_we` is high and reads returned combinationally on `cfg_rdata`:
- 0: software control. Bit 31 is the enable bit.
- 1: channel control. Bit 0 is the halt bit.
- 2: descriptor address.
- 3: status, read-only. Bit 0 is busy.
- 4: interrupt status. Bit 0 is disable-acknowledge; writing 1 clears it.
- Any other address reads 0.

Top module: `sgc_chain_engine`

## Requirements
- R1: After reset the enable bit reads 0, the halt bit reads 1, the descriptor address reads 0, busy and the interrupt status read 0, `irq` is low and no memory request is made.
- R2: The chain starts only while enable is 1 and halt is 0. With either condition missing, the sequencer issues no memory request.
- R3: Without a pending resume, a start fetches the descriptor whose base is in the address register. The words are read in offset order +0 to +5, and then one mover command is issued carrying the source, destination and length words.
- R4: The status word at +5 is written only after `mv_done`. The written value is the fetched status with bit 31 cleared and every other bit kept.
- R5: After each status write-back the descriptor address register holds that descriptor's base. The sequencer then continues at the link pointer read from +0.
- R6: If control bit 31 of a descriptor is set, the sequencer completes that descriptor, fetches nothing further and sets the halt bit. If that set lands in the same cycle as a software write to the halt bit, the set wins.
- R7: If enable is 0 when a descriptor completes, the sequencer stops after that descriptor and sets the disable-acknowledge bit, which drives `irq` high. The halt bit stays as it was.
- R8: Writing 1 to interrupt-status bit 0 clears it. Writing 0 leaves it unchanged. A set raised by hardware in the same cycle wins over the clear.
- R9: Status bit 0 reads 1 from the start of a chain until it stops.
- R10: Once a descriptor has completed, the next start first reads the link word (+0) of the descriptor in the address register and then processes the descriptor it points to. A software write to the address register while the chain is idle cancels this, so the next start begins at the written address.
- R11: A memory request holds its fields until accepted, and no new request is made until the previous one has been answered.
- R12: Software writes to the descriptor address register are ignored while the chain is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Interrupt, high while any interrupt status bit is set |
| mem_req_valid | output | 1 | Descriptor memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_data | input | DW | Read data |
| mv_cmd_valid | output | 1 | Transfer command valid |
| mv_cmd_ready | input | 1 | Mover accepts the command |
| mv_src | output | DW | Source address word |
| mv_dst | output | DW | Destination address word |
| mv_len | output | DW | Length word |
| mv_done | input | 1 | Transfer finished pulse |

## Verification
The bench targets the following corner cases:
- **Descriptor stop bit.** A sequencer that stops before the flagged descriptor would lose one move and one write-back. One that ignores the flag would keep reading past it.
- **Resume versus rewrite.** A design that confuses the two would either reprocess the last completed descriptor or skip the one software pointed at.
- **Disable landing mid-descriptor.** A design that stops abruptly would show fewer write-backs than moves or leave the acknowledge bit clear.
- **Write-one-to-clear, address writes while busy, and write ordering.** A wrong write-one-to-clear would drop the bit when 0 is written. Letting an address write through while busy would corrupt the recorded position. The write-back order is also checked against the mover's done pulse, under random memory and mover stalls.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int unsigned NUM_FETCH = 6;
  localparam int unsigned OFS_NEXT  = 0;
  localparam int unsigned OFS_CTRL  = 1;
  localparam int unsigned OFS_SRC   = 2;
  localparam int unsigned OFS_DST   = 3;
  localparam int unsigned OFS_LEN   = 4;
  localparam int unsigned OFS_STAT  = 5;

  localparam int unsigned HALT_BIT  = 0;
  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned DACK_BIT  = 0;

  localparam logic [2:0] RA_SWCTL = 3'd0;
  localparam logic [2:0] RA_CHCTL = 3'd1;
  localparam logic [2:0] RA_DADDR = 3'd2;
  localparam logic [2:0] RA_STAT  = 3'd3;
  localparam logic [2:0] RA_INT   = 3'd4;

  typedef enum logic [2:0] {
    W_IDLE, W_LINK, W_FETCH, W_MOVE, W_WAITMV, W_WBACK
  } walk_st_e;

  typedef enum logic [1:0] {
    P_IDLE, P_REQ, P_WAIT
  } port_st_e;
endpackage

// File: rtl/sgc_regs.sv
module sgc_regs
  import sgc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          eng_busy,
  input  logic          cmpl_valid,
  input  logic [AW-1:0] cmpl_addr,
  input  logic          set_halt,
  input  logic          set_dack,
  output logic          sw_enable,
  output logic          ch_halt,
  output logic [AW-1:0] desc_addr,
  output logic          resume,
  output logic          irq
);
  localparam int unsigned EN_BIT = DW - 1;

  logic          en_q, halt_q, dack_q, resume_q;
  logic [AW-1:0] daddr_q;
  logic          wr_swctl, wr_chctl, wr_daddr, wr_int;

  assign wr_swctl = cfg_we && (cfg_addr == RA_SWCTL);
  assign wr_chctl = cfg_we && (cfg_addr == RA_CHCTL);
  assign wr_daddr = cfg_we && (cfg_addr == RA_DADDR) && !eng_busy;
  assign wr_int   = cfg_we && (cfg_addr == RA_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      halt_q   <= 1'b1;
      daddr_q  <= '0;
      dack_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      if (wr_swctl) en_q <= cfg_wdata[EN_BIT];
      if (set_halt) halt_q <= 1'b1;
      else if (wr_chctl) halt_q <= cfg_wdata[HALT_BIT];
      if (cmpl_valid) begin
        daddr_q  <= cmpl_addr;
        resume_q <= 1'b1;
      end else if (wr_daddr) begin
        daddr_q  <= cfg_wdata[AW-1:0];
        resume_q <= 1'b0;
      end
      if (set_dack) dack_q <= 1'b1;
      else if (wr_int && cfg_wdata[DACK_BIT]) dack_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      RA_SWCTL: cfg_rdata[EN_BIT]     = en_q;
      RA_CHCTL: cfg_rdata[HALT_BIT]   = halt_q;
      RA_DADDR: cfg_rdata[AW-1:0]     = daddr_q;
      RA_STAT:  cfg_rdata[BUSY_BIT]   = eng_busy;
      RA_INT:   cfg_rdata[DACK_BIT]   = dack_q;
      default:  cfg_rdata             = '0;
    endcase
  end

  assign sw_enable = en_q;
  assign ch_halt   = halt_q;
  assign desc_addr = daddr_q;
  assign resume    = resume_q;
  assign irq       = dack_q;

  p_halt_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_halt |=> ch_halt);

  p_dack_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack_q) |-> $past(set_dack));

  p_addr_frozen_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !cmpl_valid) |=> (desc_addr == $past(desc_addr)));
endmodule

// File: rtl/sgc_mem_port.sv
module sgc_mem_port
  import sgc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_write,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  port_st_e      st;
  logic          write_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st)
        P_IDLE: if (go) begin
          st      <= P_REQ;
          write_q <= go_write;
          addr_q  <= go_addr;
          wdata_q <= go_wdata;
        end
        P_REQ:  if (mem_req_ready) st <= P_WAIT;
        P_WAIT: if (mem_rsp_valid) st <= P_IDLE;
        default: st <= P_IDLE;
      endcase
    end
  end

  assign idle          = (st == P_IDLE);
  assign done          = (st == P_WAIT) && mem_rsp_valid;
  assign rdata         = mem_rsp_data;
  assign mem_req_valid = (st == P_REQ);
  assign mem_req_write = write_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_go_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == P_IDLE));
endmodule

// File: rtl/sgc_walker.sv
module sgc_walker
  import sgc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_enable,
  input  logic          ch_halt,
  input  logic [AW-1:0] start_addr,
  input  logic          resume,
  input  logic          acc_idle,
  input  logic          acc_done,
  input  logic [DW-1:0] acc_rdata,
  output logic          acc_go,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          mv_cmd_valid,
  input  logic          mv_cmd_ready,
  output logic [DW-1:0] mv_src,
  output logic [DW-1:0] mv_dst,
  output logic [DW-1:0] mv_len,
  input  logic          mv_done,
  output logic          busy,
  output logic          cmpl_valid,
  output logic [AW-1:0] cmpl_addr,
  output logic          set_halt,
  output logic          set_dack
);
  localparam int unsigned NW       = NUM_FETCH;
  localparam int unsigned IW       = $clog2(NW);
  localparam int unsigned FLAG_BIT = DW - 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

  walk_st_e          st;
  logic [AW-1:0]     cur;
  logic [IW-1:0]     idx;
  logic [NW-1:0][DW-1:0] words;
  logic              stop_now;

  for (genvar g = 0; g < NW; g++) begin : g_cap
    logic [DW-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else if (st == W_FETCH && acc_done && idx == IW'(g)) w_q <= acc_rdata;
    end
    assign words[g] = w_q;
  end

  assign stop_now = words[OFS_CTRL][FLAG_BIT] || !sw_enable || ch_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= W_IDLE;
      cur <= '0;
      idx <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (sw_enable && !ch_halt) begin
          cur <= start_addr;
          idx <= '0;
          st  <= resume ? W_LINK : W_FETCH;
        end
        W_LINK: if (acc_done) begin
          cur <= acc_rdata[AW-1:0];
          st  <= W_FETCH;
        end
        W_FETCH: if (acc_done) begin
          if (idx == LAST_IDX) st <= W_MOVE;
          else idx <= idx + 1'b1;
        end
        W_MOVE:   if (mv_cmd_ready) st <= W_WAITMV;
        W_WAITMV: if (mv_done) st <= W_WBACK;
        W_WBACK: if (acc_done) begin
          if (stop_now) st <= W_IDLE;
          else begin
            cur <= words[OFS_NEXT][AW-1:0];
            idx <= '0;
            st  <= W_FETCH;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    acc_addr = cur;
    unique case (st)
      W_LINK:  acc_addr = cur + AW'(OFS_NEXT);
      W_FETCH: acc_addr = cur + {{(AW-IW){1'b0}}, idx};
      W_WBACK: acc_addr = cur + AW'(OFS_STAT);
      default: acc_addr = cur;
    endcase
  end

  always_comb begin
    acc_wdata           = words[OFS_STAT];
    acc_wdata[FLAG_BIT] = 1'b0;
  end

  assign acc_go       = acc_idle && (st == W_LINK || st == W_FETCH || st == W_WBACK);
  assign acc_write    = (st == W_WBACK);
  assign mv_cmd_valid = (st == W_MOVE);
  assign mv_src       = words[OFS_SRC];
  assign mv_dst       = words[OFS_DST];
  assign mv_len       = words[OFS_LEN];
  assign busy         = (st != W_IDLE);
  assign cmpl_valid   = (st == W_WBACK) && acc_done;
  assign cmpl_addr    = cur;
  assign set_halt     = cmpl_valid && words[OFS_CTRL][FLAG_BIT];
  assign set_dack     = cmpl_valid && !sw_enable;

  p_wb_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == W_WBACK) |-> $past(mv_done));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_cmd_valid && !mv_cmd_ready) |=>
      (mv_cmd_valid && $stable(mv_src) && $stable(mv_dst) && $stable(mv_len)));

  p_halt_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_halt |=> (!busy && !acc_go));
endmodule

// File: rtl/sgc_chain_engine.sv
module sgc_chain_engine
  import sgc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          mv_cmd_valid,
  input  logic          mv_cmd_ready,
  output logic [DW-1:0] mv_src,
  output logic [DW-1:0] mv_dst,
  output logic [DW-1:0] mv_len,
  input  logic          mv_done
);
  logic          sw_enable, ch_halt, resume, eng_busy;
  logic [AW-1:0] desc_addr, cmpl_addr, acc_addr;
  logic          cmpl_valid, set_halt, set_dack;
  logic          acc_go, acc_write, acc_idle, acc_done;
  logic [DW-1:0] acc_wdata, acc_rdata;

  sgc_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .eng_busy(eng_busy), .cmpl_valid(cmpl_valid), .cmpl_addr(cmpl_addr),
    .set_halt(set_halt), .set_dack(set_dack),
    .sw_enable(sw_enable), .ch_halt(ch_halt), .desc_addr(desc_addr),
    .resume(resume), .irq(irq)
  );

  sgc_walker #(.DW(DW), .AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .sw_enable(sw_enable), .ch_halt(ch_halt), .start_addr(desc_addr), .resume(resume),
    .acc_idle(acc_idle), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .acc_go(acc_go), .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .mv_cmd_valid(mv_cmd_valid), .mv_cmd_ready(mv_cmd_ready),
    .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .mv_done(mv_done),
    .busy(eng_busy), .cmpl_valid(cmpl_valid), .cmpl_addr(cmpl_addr),
    .set_halt(set_halt), .set_dack(set_dack)
  );

  sgc_mem_port #(.DW(DW), .AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .go(acc_go), .go_write(acc_write), .go_addr(acc_addr), .go_wdata(acc_wdata),
    .idle(acc_idle), .done(acc_done), .rdata(acc_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && (!sw_enable || ch_halt)) |=> !eng_busy);
endmodule

// File: tb/test_sgc_chain_engine.sv
module test_sgc_chain_engine;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int ND = 6;
  localparam logic [31:0] TOP = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = 3'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          irq;
  logic          mem_req_valid, mem_req_write;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          mv_cmd_valid;
  logic          mv_cmd_ready = 1'b0;
  logic [DW-1:0] mv_src, mv_dst, mv_len;
  logic          mv_done = 1'b0;

  sgc_chain_engine #(.DW(DW), .AW(AW)) i_sgc_chain_engine (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [0:255];
  int rd_log [0:1023];
  int wr_a [0:255];
  logic [31:0] wr_d [0:255];
  logic [31:0] ms [0:255], md [0:255], ml [0:255];
  int rd_n = 0, wr_n = 0, mv_n = 0, done_n = 0;
  int order_err = 0, overlap_err = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] orig_stat [0:ND-1];

  function automatic int base_of(int i);
    return 16 * (i + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random accept stalls and response latency
  initial begin : mem_model
    bit pend = 0;
    int dly = 0;
    logic [31:0] pdata = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (mem_req_valid) overlap_err++;
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0;
        end else dly--;
      end else if (mem_req_valid && ($urandom % 4 != 0)) begin
        mem_req_ready = 1'b1;
        if (mem_req_write) begin
          if (done_n != mv_n) order_err++;
          mem[mem_req_addr[7:0]] = mem_req_wdata;
          wr_a[wr_n] = int'(mem_req_addr); wr_d[wr_n] = mem_req_wdata; wr_n++;
          pdata = '0;
        end else begin
          pdata = mem[mem_req_addr[7:0]];
          rd_log[rd_n] = int'(mem_req_addr); rd_n++;
        end
        pend = 1; dly = $urandom % 3;
      end
    end
  end

  // mover model
  initial begin : mover_model
    bit pend = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      mv_cmd_ready = 1'b0;
      mv_done = 1'b0;
      if (pend) begin
        if (dly == 0) begin mv_done = 1'b1; pend = 0; done_n++; end
        else dly--;
      end else if (mv_cmd_valid && ($urandom % 3 != 0)) begin
        mv_cmd_ready = 1'b1;
        ms[mv_n] = mv_src; md[mv_n] = mv_dst; ml[mv_n] = mv_len; mv_n++;
        pend = 1; dly = 1 + $urandom % 5;
      end
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic build_ring(input int stop_idx);
    for (int i = 0; i < ND; i++) begin
      int b = base_of(i);
      mem[b + 0] = 32'(base_of((i + 1) % ND));
      mem[b + 1] = ((i == stop_idx) ? TOP : 32'h0) | ($urandom & 32'hFFFF);
      mem[b + 2] = $urandom;
      mem[b + 3] = $urandom;
      mem[b + 4] = $urandom & 32'hFFFF;
      mem[b + 5] = TOP | ($urandom & 32'h00FF_FFFF);
      mem[b + 6] = 32'hDEAD_0000 + 32'(i);
      orig_stat[i] = mem[b + 5];
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; mv_n = 0; done_n = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 6000; i++) begin
      cfg_read(sgc_pkg::RA_STAT, v);
      if (v[0]) seen = 1;
      else if (seen) break;
    end
  endtask

  // checks one completed run: optional link read, reads, moves, write-backs, address register
  task automatic check_run(input int first, input int cnt, input int link_base);
    int off = 0;
    int bad_rd = 0;
    logic [31:0] v;
    if (link_base >= 0) begin
      chk("R10 link word read first", 32'(rd_log[0]), 32'(link_base));
      off = 1;
    end
    chk("R3 read count", 32'(rd_n), 32'(off + 6 * cnt));
    chk("R3 move count", 32'(mv_n), 32'(cnt));
    chk("R4 write-back count", 32'(wr_n), 32'(cnt));
    for (int k = 0; k < cnt; k++) begin
      int i = (first + k) % ND;
      int b = base_of(i);
      for (int w = 0; w < 6; w++)
        if (off + 6 * k + w < rd_n && rd_log[off + 6 * k + w] != b + w) bad_rd++;
      if (k < mv_n) begin
        chk("R3 move source", ms[k], mem[b + 2]);
        chk("R3 move dest", md[k], mem[b + 3]);
        chk("R3 move length", ml[k], mem[b + 4]);
      end
      if (k < wr_n) begin
        chk("R4 write-back addr", 32'(wr_a[k]), 32'(b + 5));
        chk("R4 write-back data", wr_d[k], orig_stat[i] & ~TOP);
      end
    end
    chk("R3 read order mismatches", 32'(bad_rd), 32'd0);
    cfg_read(sgc_pkg::RA_DADDR, v);
    chk("R5 address register", v, 32'(base_of((first + cnt - 1) % ND)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int m, snap;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_read(sgc_pkg::RA_SWCTL, v); chk("R1 enable after reset", v, 32'h0);
    cfg_read(sgc_pkg::RA_CHCTL, v); chk("R1 halt after reset", v, 32'h1);
    cfg_read(sgc_pkg::RA_DADDR, v); chk("R1 address after reset", v, 32'h0);
    cfg_read(sgc_pkg::RA_STAT, v);  chk("R1 busy after reset", v, 32'h0);
    cfg_read(sgc_pkg::RA_INT, v);   chk("R1 int after reset", v, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 no request after reset", 32'(mem_req_valid), 32'h0);

    // R2 gating
    build_ring(2);
    clear_logs();
    cfg_write(sgc_pkg::RA_SWCTL, TOP);
    repeat (20) @(negedge clk);
    chk("R2 enable alone starts nothing", 32'(rd_n), 32'd0);
    cfg_write(sgc_pkg::RA_SWCTL, 32'h0);
    cfg_write(sgc_pkg::RA_CHCTL, 32'h0);
    repeat (20) @(negedge clk);
    chk("R2 halt clear alone starts nothing", 32'(rd_n), 32'd0);

    // R3/R4/R5/R6 directed chain ending on stop flag at descriptor 2
    cfg_write(sgc_pkg::RA_DADDR, 32'(base_of(0)));
    cfg_write(sgc_pkg::RA_SWCTL, TOP);
    wait_idle();
    check_run(0, 3, -1);
    cfg_read(sgc_pkg::RA_CHCTL, v); chk("R6 halt set by stop flag", v, 32'h1);
    cfg_read(sgc_pkg::RA_INT, v);   chk("R6 no ack on flag stop", v, 32'h0);
    snap = rd_n;
    repeat (30) @(negedge clk);
    chk("R6 nothing fetched after stop", 32'(rd_n), 32'(snap));

    // R10 resume from last completed
    build_ring(4);
    clear_logs();
    cfg_write(sgc_pkg::RA_CHCTL, 32'h0);
    wait_idle();
    check_run(3, 2, base_of(2));

    // R10 software rewrite while idle cancels resume
    build_ring(1);
    clear_logs();
    cfg_write(sgc_pkg::RA_DADDR, 32'(base_of(1)));
    cfg_write(sgc_pkg::RA_CHCTL, 32'h0);
    wait_idle();
    check_run(1, 1, -1);

    // R7 graceful disable, R9 busy, R12 address write ignored while busy
    build_ring(-1);
    clear_logs();
    cfg_write(sgc_pkg::RA_CHCTL, 32'h0);
    for (int i = 0; i < 3000 && mv_n < 1; i++) @(negedge clk);
    cfg_read(sgc_pkg::RA_STAT, v); chk("R9 busy during run", v, 32'h1);
    cfg_write(sgc_pkg::RA_DADDR, 32'h7);
    cfg_write(sgc_pkg::RA_SWCTL, 32'h0);
    wait_idle();
    m = mv_n;
    chk("R7 at least one descriptor", 32'(m >= 1), 32'd1);
    chk("R7 every moved descriptor written back", 32'(wr_n), 32'(m));
    chk("R7 no fetch beyond last", 32'(rd_n), 32'(1 + 6 * m));
    cfg_read(sgc_pkg::RA_DADDR, v);
    chk("R12 address kept, busy write ignored", v, 32'(base_of((2 + m - 1) % ND)));
    cfg_read(sgc_pkg::RA_INT, v); chk("R7 ack bit set", v, 32'h1);
    chk("R7 irq raised", 32'(irq), 32'h1);
    cfg_read(sgc_pkg::RA_CHCTL, v); chk("R7 halt untouched", v, 32'h0);
    snap = rd_n;
    repeat (30) @(negedge clk);
    chk("R7 stays stopped", 32'(rd_n), 32'(snap));

    // R8 write-one-to-clear
    cfg_write(sgc_pkg::RA_INT, 32'h0);
    cfg_read(sgc_pkg::RA_INT, v); chk("R8 write 0 keeps bit", v, 32'h1);
    cfg_write(sgc_pkg::RA_INT, 32'h1);
    cfg_read(sgc_pkg::RA_INT, v); chk("R8 write 1 clears bit", v, 32'h0);
    chk("R8 irq drops", 32'(irq), 32'h0);

    // random chains with random start and length
    cfg_write(sgc_pkg::RA_CHCTL, 32'h1);
    cfg_write(sgc_pkg::RA_SWCTL, TOP);
    for (int r = 0; r < 8; r++) begin
      int s = $urandom % ND;
      int len = 1 + $urandom % ND;
      build_ring((s + len - 1) % ND);
      clear_logs();
      cfg_write(sgc_pkg::RA_DADDR, 32'(base_of(s)));
      cfg_write(sgc_pkg::RA_CHCTL, 32'h0);
      wait_idle();
      check_run(s, len, -1);
      cfg_read(sgc_pkg::RA_CHCTL, v); chk("R6 halt set after random chain", v, 32'h1);
    end
    cfg_read(sgc_pkg::RA_INT, v); chk("R7 no ack while enabled", v, 32'h0);

    chk("R4 no write-back before mover done", 32'(order_err), 32'd0);
    chk("R11 no request while one outstanding", 32'(overlap_err), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule